// File: doc/BRIEF.md
# Ping-Pong Endpoint Packet Buffer

This block holds packet data for a single bulk or isochronous endpoint in two alternating banks. At any moment the USB-side packet engine works on one bank while the local DMA byte interface works on the other. When a side has finished with its bank it hands that bank over and moves on to the other one. Each side keeps its own bank pointer, and that pointer toggles only when the side releases its bank.

The direction is fixed by a configuration input, and the block works the same way in both directions. In the receive direction the host writes a packet into a bank. The bank becomes readable by DMA only once the packet is closed, and it keeps the packet's own length, so a short packet ends on its true last byte. In the transmit direction DMA fills a bank. The bank is handed to the USB side when it is full, or earlier when an end-of-transfer indication arrives. It stays with the USB side until the transmission is reported successful. An IN token that finds no ready bank produces a no-data indication.

Bank capacity is 64 bytes normally and 128 bytes when the endpoint is configured for one-direction isochronous use. Per-bank ready flags and a last-byte flag feed the DMA request logic outside this block.

Top module: `ep_pingpong_buf`

## Requirements
- R1: After reset both banks are empty and not ready: `bank_full_o` = 2'b00, `dma_avail_o` = 0, `dma_last_o` = 0 and `usb_nak_o` = 0. The first packet or fill on either side uses bank 0.
- R2: Receive (`dir_tx_i` = 0): bytes written by the USB side do not make a bank visible to DMA. The bank becomes ready (its `bank_full_o` bit set, `dma_avail_o` = 1) on the clock edge that samples `usb_pkt_end_i`. A packet end on an empty bank is ignored.
- R3: Receive: `dma_rdata_o` shows the current byte of the DMA-side bank before it is read, and bytes come out in write order. `dma_last_o` is high exactly while the current index equals the packet length minus one. Reading that byte frees the bank.
- R4: The two banks alternate. The USB side fills the other bank while DMA drains the first. The USB pointer advances only when a bank is committed, and the DMA pointer advances only when DMA commits or frees a bank. `bank_full_o` bit b is the ready flag of bank b.
- R5: Capacity is 64 bytes when `iso_single_i` = 0 and 128 bytes when it is 1. Receive writes beyond capacity, and writes while the USB-side bank is still ready, are dropped and leave `usb_len_o` unchanged.
- R6: Transmit (`dir_tx_i` = 1): a bank becomes ready only when DMA writes its last byte of capacity. `dma_avail_o` is 1 while the DMA-side bank is free and 0 when both banks are ready. DMA writes made while the DMA-side bank is ready are dropped.
- R7: Transmit: `dma_eot_i` commits a partially filled DMA-side bank with its current byte count. On an empty bank it is ignored.
- R8: Transmit: an `usb_in_tok_i` that finds the USB-side bank not ready raises `usb_nak_o` for one cycle, on the following cycle. A token that finds a ready bank leaves `usb_nak_o` low.
- R9: Transmit: `usb_tx_done_i` with `usb_tx_ok_i` = 1 frees the USB-side bank and moves the USB pointer to the other bank. With `usb_tx_ok_i` = 0 the bank stays ready and the read index returns to byte 0.
- R10: `dma_last_o` stays 0 in transmit, and IN tokens are ignored in receive (`usb_nak_o` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_tx_i | input | 1 | 0 receive, 1 transmit |
| iso_single_i | input | 1 | 1 selects 128-byte banks |
| usb_wr_i | input | 1 | USB-side byte write (receive) |
| usb_wdata_i | input | 8 | USB-side write byte |
| usb_pkt_end_i | input | 1 | Close the received packet |
| usb_in_tok_i | input | 1 | IN token seen (transmit) |
| usb_nak_o | output | 1 | No-data response for the last IN token |
| usb_tx_rdy_o | output | 1 | USB-side bank ready to send |
| usb_len_o | output | 8 | Byte count of the USB-side bank |
| usb_rd_i | input | 1 | Advance USB read index (transmit) |
| usb_rdata_o | output | 8 | Current USB-side read byte |
| usb_tx_done_i | input | 1 | Transmission finished |
| usb_tx_ok_i | input | 1 | Transmission acknowledged |
| dma_wr_i | input | 1 | DMA byte write (transmit) |
| dma_wdata_i | input | 8 | DMA write byte |
| dma_eot_i | input | 1 | DMA end of transfer |
| dma_rd_i | input | 1 | DMA byte read (receive) |
| dma_rdata_o | output | 8 | Current DMA read byte |
| dma_avail_o | output | 1 | DMA-side bank can be serviced |
| dma_last_o | output | 1 | Current DMA byte ends the packet |
| bank_full_o | output | 2 | Ready flag per bank |

## Verification
In receive, the USB side can close a packet in bank 1 in the same cycle that DMA reads the final byte of bank 0. The bench provokes this by driving the last host byte, the packet end and the DMA read of the final byte on one edge. It then checks that bank 1 is ready, bank 0 is free and the next DMA byte is the first byte of the new packet. In transmit, a DMA end-of-transfer and a failed or successful transmission meet with both banks in flight. The bench confirms that the ready flags, the byte counts and the read data each follow the rule of their own side.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } ep_dir_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/ep_pp_bank.sv
module ep_pp_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              release_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              ready_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  count_q;
  logic              ready_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[count_q[IDX_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ready_q <= 1'b0;
    end else if (release_i) begin
      count_q <= '0;
      ready_q <= 1'b0;
    end else begin
      if (wr_en_i)  count_q <= count_q + CNT_W'(1);
      if (commit_i) ready_q <= 1'b1;
    end
  end

  assign ready_o   = ready_q;
  assign count_o   = count_q;
  assign rd_data_o = mem_q[rd_idx_i];

  // a ready bank is owned by the reader; the writer must be gated off
  a_r2_no_write_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !ready_q);
  a_r5_no_write_past_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (count_q < cap_i));
  a_r9_ready_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && !release_i) |=> ready_q);
  a_r4_release_only_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> ready_q);
endmodule

// File: rtl/ep_pp_port.sv
module ep_pp_port #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             rewind_i,
  input  logic             release_i,
  output logic             ptr_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             ptr_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= 1'b0;
      idx_q <= '0;
    end else if (release_i) begin
      ptr_q <= ~ptr_q;
      idx_q <= '0;
    end else if (rewind_i) begin
      idx_q <= '0;
    end else if (advance_i) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign ptr_o = ptr_q;
  assign idx_o = idx_q;

  a_r4_ptr_moves_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !release_i |=> $stable(ptr_q));
  a_r9_rewind_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rewind_i && !release_i) |=> (idx_q == '0));
endmodule

// File: rtl/ep_pingpong_buf.sv
module ep_pingpong_buf
  import ep_buf_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NORM_BYTES = 64,
  parameter int unsigned ISO_BYTES  = 128,
  localparam int unsigned MAX_BYTES = (ISO_BYTES > NORM_BYTES) ? ISO_BYTES : NORM_BYTES,
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W     = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_tx_i,
  input  logic              iso_single_i,
  input  logic              usb_wr_i,
  input  logic [DATA_W-1:0] usb_wdata_i,
  input  logic              usb_pkt_end_i,
  input  logic              usb_in_tok_i,
  output logic              usb_nak_o,
  output logic              usb_tx_rdy_o,
  output logic [CNT_W-1:0]  usb_len_o,
  input  logic              usb_rd_i,
  output logic [DATA_W-1:0] usb_rdata_o,
  input  logic              usb_tx_done_i,
  input  logic              usb_tx_ok_i,
  input  logic              dma_wr_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  input  logic              dma_eot_i,
  input  logic              dma_rd_i,
  output logic [DATA_W-1:0] dma_rdata_o,
  output logic              dma_avail_o,
  output logic              dma_last_o,
  output logic [NUM_BANKS-1:0] bank_full_o
);
  ep_dir_e dir;
  logic [CNT_W-1:0] cap;

  logic [NUM_BANKS-1:0]             bk_ready, bk_wr, bk_commit, bk_release;
  logic [NUM_BANKS-1:0][CNT_W-1:0]  bk_cnt;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bk_rdata;
  logic [DATA_W-1:0]                bk_wdata;
  logic [IDX_W-1:0]                 bk_ridx;

  logic             u_ptr, d_ptr;
  logic [IDX_W-1:0] u_idx, d_idx;

  logic usb_acc, usb_commit, usb_rd_ok, usb_done, usb_release, usb_rewind;
  logic dma_acc, dma_commit, dma_rd_ok, dma_is_last, dma_release;
  logic nak_q;

  assign dir = ep_dir_e'(dir_tx_i);
  assign cap = iso_single_i ? CNT_W'(ISO_BYTES) : CNT_W'(NORM_BYTES);

  always_comb begin
    // receive: USB writes, DMA reads
    usb_acc     = (dir == DIR_RX) && usb_wr_i && !bk_ready[u_ptr] && (bk_cnt[u_ptr] < cap);
    usb_commit  = (dir == DIR_RX) && usb_pkt_end_i && !bk_ready[u_ptr]
                  && ((bk_cnt[u_ptr] != '0) || usb_acc);
    dma_is_last = bk_ready[d_ptr] && ((CNT_W'(d_idx) + CNT_W'(1)) == bk_cnt[d_ptr]);
    dma_rd_ok   = (dir == DIR_RX) && dma_rd_i && bk_ready[d_ptr];
    dma_release = dma_rd_ok && dma_is_last;
    // transmit: DMA writes, USB reads
    dma_acc     = (dir == DIR_TX) && dma_wr_i && !bk_ready[d_ptr] && (bk_cnt[d_ptr] < cap);
    dma_commit  = (dma_acc && ((bk_cnt[d_ptr] + CNT_W'(1)) == cap))
                  || ((dir == DIR_TX) && dma_eot_i && !bk_ready[d_ptr]
                      && ((bk_cnt[d_ptr] != '0) || dma_acc));
    usb_rd_ok   = (dir == DIR_TX) && usb_rd_i && bk_ready[u_ptr];
    usb_done    = (dir == DIR_TX) && usb_tx_done_i && bk_ready[u_ptr];
    usb_release = usb_done && usb_tx_ok_i;
    usb_rewind  = usb_done && !usb_tx_ok_i;
  end

  assign bk_wdata = (dir == DIR_TX) ? dma_wdata_i : usb_wdata_i;
  assign bk_ridx  = (dir == DIR_TX) ? u_idx : d_idx;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bk_wr[b]      = (usb_acc && (u_ptr == b[0])) || (dma_acc && (d_ptr == b[0]));
    assign bk_commit[b]  = (usb_commit && (u_ptr == b[0])) || (dma_commit && (d_ptr == b[0]));
    assign bk_release[b] = (dma_release && (d_ptr == b[0])) || (usb_release && (u_ptr == b[0]));

    ep_pp_bank #(
      .DATA_W (DATA_W),
      .DEPTH  (MAX_BYTES)
    ) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_i     (cap),
      .wr_en_i   (bk_wr[b]),
      .wr_data_i (bk_wdata),
      .commit_i  (bk_commit[b]),
      .release_i (bk_release[b]),
      .rd_idx_i  (bk_ridx),
      .ready_o   (bk_ready[b]),
      .count_o   (bk_cnt[b]),
      .rd_data_o (bk_rdata[b])
    );
  end

  ep_pp_port #(.IDX_W(IDX_W)) i_usb_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (usb_rd_ok),
    .rewind_i  (usb_rewind),
    .release_i (usb_commit || usb_release),
    .ptr_o     (u_ptr),
    .idx_o     (u_idx)
  );

  ep_pp_port #(.IDX_W(IDX_W)) i_dma_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (dma_rd_ok && !dma_is_last),
    .rewind_i  (1'b0),
    .release_i (dma_release || dma_commit),
    .ptr_o     (d_ptr),
    .idx_o     (d_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nak_q <= 1'b0;
    else         nak_q <= (dir == DIR_TX) && usb_in_tok_i && !bk_ready[u_ptr];
  end

  assign usb_nak_o    = nak_q;
  assign usb_tx_rdy_o = (dir == DIR_TX) && bk_ready[u_ptr];
  assign usb_len_o    = bk_cnt[u_ptr];
  assign usb_rdata_o  = bk_rdata[u_ptr];
  assign dma_rdata_o  = bk_rdata[d_ptr];
  assign dma_avail_o  = (dir == DIR_TX) ? !bk_ready[d_ptr] : bk_ready[d_ptr];
  assign dma_last_o   = (dir == DIR_RX) && dma_is_last;
  assign bank_full_o  = bk_ready;

  a_r8_no_nak_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_tx_rdy_o && usb_in_tok_i) |=> !usb_nak_o);
  a_r3_last_needs_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_last_o |-> dma_avail_o);
  a_r10_no_last_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_tx_i |-> !dma_last_o);
  a_r2_commit_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_commit |=> (bank_full_o[$past(u_ptr)] == 1'b1));
endmodule

// File: tb/test_ep_pingpong_buf.sv
module test_ep_pingpong_buf;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 50000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dir_tx_i = 1'b0, iso_single_i = 1'b0;
  logic       usb_wr_i = 1'b0, usb_pkt_end_i = 1'b0, usb_in_tok_i = 1'b0;
  logic [7:0] usb_wdata_i = '0;
  logic       usb_nak_o, usb_tx_rdy_o;
  logic [7:0] usb_len_o, usb_rdata_o;
  logic       usb_rd_i = 1'b0, usb_tx_done_i = 1'b0, usb_tx_ok_i = 1'b0;
  logic       dma_wr_i = 1'b0, dma_eot_i = 1'b0, dma_rd_i = 1'b0;
  logic [7:0] dma_wdata_i = '0;
  logic [7:0] dma_rdata_o;
  logic       dma_avail_o, dma_last_o;
  logic [1:0] bank_full_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ep_pingpong_buf i_ep_pingpong_buf (
    .clk_i, .rst_ni, .dir_tx_i, .iso_single_i,
    .usb_wr_i, .usb_wdata_i, .usb_pkt_end_i, .usb_in_tok_i,
    .usb_nak_o, .usb_tx_rdy_o, .usb_len_o, .usb_rd_i, .usb_rdata_o,
    .usb_tx_done_i, .usb_tx_ok_i,
    .dma_wr_i, .dma_wdata_i, .dma_eot_i, .dma_rd_i,
    .dma_rdata_o, .dma_avail_o, .dma_last_o, .bank_full_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset(input logic tx, input logic iso);
    rst_ni = 1'b0;
    dir_tx_i = tx;
    iso_single_i = iso;
    tick();
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic usb_put(input logic [7:0] d);
    usb_wr_i = 1'b1; usb_wdata_i = d; tick(); usb_wr_i = 1'b0;
  endtask

  task automatic usb_end();
    usb_pkt_end_i = 1'b1; tick(); usb_pkt_end_i = 1'b0;
  endtask

  task automatic dma_get(input string req, input logic [7:0] exp, input logic last);
    chk(req, dma_rdata_o, exp);
    chk(req, dma_last_o, last);
    dma_rd_i = 1'b1; tick(); dma_rd_i = 1'b0;
  endtask

  task automatic dma_put(input logic [7:0] d);
    dma_wr_i = 1'b1; dma_wdata_i = d; tick(); dma_wr_i = 1'b0;
  endtask

  task automatic dma_end();
    dma_eot_i = 1'b1; tick(); dma_eot_i = 1'b0;
  endtask

  task automatic in_token();
    usb_in_tok_i = 1'b1; tick(); usb_in_tok_i = 1'b0;
  endtask

  task automatic usb_get(input string req, input logic [7:0] exp);
    chk(req, usb_rdata_o, exp);
    usb_rd_i = 1'b1; tick(); usb_rd_i = 1'b0;
  endtask

  task automatic tx_done(input logic ok);
    usb_tx_done_i = 1'b1; usb_tx_ok_i = ok; tick();
    usb_tx_done_i = 1'b0; usb_tx_ok_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R1 full", bank_full_o, 2'b00);
    chk("R1 avail", dma_avail_o, 1'b0);
    chk("R1 last", dma_last_o, 1'b0);
    chk("R1 nak", usb_nak_o, 1'b0);
  endtask

  task automatic t_rx_basic();
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) usb_put(8'h10 + 8'(i));
    chk("R2 not visible", dma_avail_o, 1'b0);
    chk("R2 len", usb_len_o, 5);
    usb_end();
    chk("R2 full", bank_full_o, 2'b01);
    chk("R2 avail", dma_avail_o, 1'b1);
    chk("R4 usb moved", usb_len_o, 0);
    for (int i = 0; i < 3; i++) usb_put(8'h20 + 8'(i));
    usb_end();
    chk("R4 both full", bank_full_o, 2'b11);
    usb_put(8'hFF);
    chk("R5 full bank write dropped", usb_len_o, 5);
    for (int i = 0; i < 5; i++) dma_get("R3 pkt A", 8'h10 + 8'(i), i == 4);
    chk("R3 freed", bank_full_o, 2'b10);
    chk("R4 dma moved", dma_rdata_o, 8'h20);
    for (int i = 0; i < 3; i++) dma_get("R3 pkt B", 8'h20 + 8'(i), i == 2);
    chk("R3 all free", bank_full_o, 2'b00);
    chk("R3 avail", dma_avail_o, 1'b0);
    usb_end();
    chk("R2 empty end ignored", bank_full_o, 2'b00);
    in_token();
    chk("R10 token in rx", usb_nak_o, 1'b0);
  endtask

  task automatic t_rx_same_cycle();
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) usb_put(8'h30 + 8'(i));
    usb_end();
    usb_put(8'h50);
    usb_put(8'h51);
    for (int i = 0; i < 3; i++) dma_get("R3 pre", 8'h30 + 8'(i), 1'b0);
    chk("R3 last flag", dma_last_o, 1'b1);
    chk("R3 last byte", dma_rdata_o, 8'h33);
    usb_wr_i = 1'b1; usb_wdata_i = 8'h52; usb_pkt_end_i = 1'b1; dma_rd_i = 1'b1;
    tick();
    usb_wr_i = 1'b0; usb_pkt_end_i = 1'b0; dma_rd_i = 1'b0;
    chk("R4 swap full", bank_full_o, 2'b10);
    chk("R4 swap avail", dma_avail_o, 1'b1);
    chk("R4 usb bank empty", usb_len_o, 0);
    for (int i = 0; i < 3; i++) dma_get("R4 pkt B", 8'h50 + 8'(i), i == 2);
    chk("R4 drained", bank_full_o, 2'b00);
  endtask

  task automatic t_rx_capacity(input logic iso, input int cap);
    do_reset(1'b0, iso);
    for (int i = 0; i < cap + 3; i++) usb_put(8'(i));
    chk("R5 capped len", usb_len_o, cap);
    usb_end();
    chk("R5 full", bank_full_o, 2'b01);
    for (int i = 0; i < cap; i++) dma_get("R5 cap read", 8'(i), i == cap - 1);
    chk("R5 freed", bank_full_o, 2'b00);
  endtask

  task automatic t_tx();
    do_reset(1'b1, 1'b0);
    in_token();
    chk("R8 nak", usb_nak_o, 1'b1);
    tick();
    chk("R8 nak one cycle", usb_nak_o, 1'b0);
    for (int i = 0; i < 63; i++) dma_put(8'h40 + 8'(i));
    chk("R6 not yet", bank_full_o, 2'b00);
    chk("R6 avail", dma_avail_o, 1'b1);
    chk("R10 no last tx", dma_last_o, 1'b0);
    dma_put(8'h7F);
    chk("R6 full", bank_full_o, 2'b01);
    chk("R6 tx rdy", usb_tx_rdy_o, 1'b1);
    chk("R6 len", usb_len_o, 64);
    chk("R6 other free", dma_avail_o, 1'b1);
    in_token();
    chk("R8 no nak", usb_nak_o, 1'b0);
    for (int i = 0; i < 4; i++) usb_get("R9 send", 8'h40 + 8'(i));
    tx_done(1'b0);
    chk("R9 retry kept", bank_full_o, 2'b01);
    chk("R9 rewind", usb_rdata_o, 8'h40);
    dma_put(8'hA0); dma_put(8'hA1); dma_put(8'hA2);
    dma_end();
    chk("R7 eot commit", bank_full_o, 2'b11);
    chk("R6 no space", dma_avail_o, 1'b0);
    dma_put(8'hEE);
    tx_done(1'b1);
    chk("R9 freed", bank_full_o, 2'b10);
    chk("R9 next rdy", usb_tx_rdy_o, 1'b1);
    chk("R7 partial len", usb_len_o, 3);
    chk("R9 next data", usb_rdata_o, 8'hA0);
    chk("R6 space back", dma_avail_o, 1'b1);
    dma_end();
    chk("R7 empty eot ignored", bank_full_o, 2'b10);
    for (int i = 0; i < 3; i++) usb_get("R7 partial data", 8'hA0 + 8'(i));
    tx_done(1'b1);
    chk("R9 all free", bank_full_o, 2'b00);
    chk("R9 not rdy", usb_tx_rdy_o, 1'b0);
    in_token();
    chk("R8 nak again", usb_nak_o, 1'b1);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rx_basic();
    t_rx_same_cycle();
    t_rx_capacity(1'b0, 64);
    t_rx_capacity(1'b1, 128);
    t_tx();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule